// File: doc/BRIEF.md
# Hypercube Dimension-Order Router Network

This block is a network of router nodes joined as a binary hypercube. Node `k` has one link to each neighbour `k ^ (1 << d)`, one for every dimension `d`, plus a local injection port and a local ejection port. Each direction of each link is a separate bit-serial channel. It has a valid bit, a data bit and a last-bit flag going forward, and a ready bit coming back. The ready bit is driven only by the receiver's buffer occupancy.

Each router collects a fixed-length serial header from every input. It then compares the destination field with its own node number. A message whose destination differs is sent out on the lowest-numbered dimension whose address bits differ. A message whose destination matches goes to local ejection. The output starts as soon as the header is complete, so the payload streams through while it is still arriving (cut-through). An output stays with one message from its first header bit to its flagged last bit. Inputs that compete for the same output are served in round-robin order. A waiting input fills its small buffer and then lowers ready, so no bit is ever dropped.

Top module: `hc_net`

## Requirements
- R1: After synchronous reset, every injection ready output is 1 and every ejection valid output is 0.
- R2: A message is a header of HDR_W bits followed by at least 8 payload bits, sent least significant bit first. Header bits [DIMS-1:0] hold the destination node, bits [DIMS+7:DIMS] hold a hop counter, and all other header bits are zero and arrive unchanged. The last flag is set only on the final payload bit.
- R3: A message injected at node s for destination t leaves the ejection port of node t, and only there. Its payload bits are identical and in the same order, and its length is unchanged.
- R4: The hop counter at ejection equals the injected value (zero) plus the Hamming distance between s and t. Each router adds one when it forwards on a dimension link.
- R5: Each router forwards on the lowest dimension where its own address differs from the destination. Routing is therefore deterministic, and messages between one source and one destination are ejected in the order they were injected.
- R6: Forwarding is cut-through. The first ejected bit of a long message appears before its last bit has been injected.
- R7: A message whose destination equals its source is ejected at the same node with a hop counter of zero.
- R8: Messages that compete for one output are each delivered whole. An output is held by one message from header to last bit and is never interleaved.
- R9: An input that waits for a busy output keeps at most FIFO_D bits and then drops ready. A stalled output register holds its bit unchanged, and no bit is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_vld | input | 2**DIMS | Injection bit valid, one per node |
| inj_dat | input | 2**DIMS | Injection data bit, one per node |
| inj_lst | input | 2**DIMS | Injection last-bit flag, one per node |
| inj_rdy | output | 2**DIMS | Injection ready (bit taken on valid and ready) |
| ej_vld | output | 2**DIMS | Ejection bit valid, one per node |
| ej_dat | output | 2**DIMS | Ejection data bit, one per node |
| ej_lst | output | 2**DIMS | Ejection last-bit flag, one per node |

## Verification
The hardest case to reach from the ports is a blocked input holding a half-received message while its upstream neighbour stalls as well. Only then do the ready back-pressure and the output hold rules matter. The stimulus builds this by sending long messages from three neighbours of one node to that node in the same cycle. All three collide on its ejection port, and stalls ripple back to the injection ports. Random source and destination traffic then mixes with repeated same-pair messages, so that ordering and hop counts are checked on paths through every dimension.

// File: rtl/hc_pkg.sv
`timescale 1ns/1ps
package hc_pkg;

    localparam int HOP_W  = 8;
    localparam int MAX_DIM = 16;

    typedef enum logic [1:0] {
        ST_HEAD  = 2'd0,
        ST_ROUTE = 2'd1,
        ST_FWD   = 2'd2
    } hc_state_e;

    typedef struct packed {
        logic dat;
        logic lst;
    } hc_bit_t;

    typedef struct packed {
        logic vld;
        logic dat;
        logic lst;
    } hc_beat_t;

    // index of the lowest set bit, MAX_DIM when none is set
    function automatic int lowest_set(input logic [MAX_DIM-1:0] v);
        int r;
        r = MAX_DIM;
        for (int i = MAX_DIM - 1; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/hc_rr_arb.sv
`timescale 1ns/1ps
module hc_rr_arb #(
    parameter int W = 5,
    localparam int PW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  req,
    input  logic          adv,
    output logic [PW-1:0] gnt_idx,
    output logic          any
);
    logic [PW-1:0] ptr;

    always_comb begin
        any     = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < W; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= W) idx = idx - W;
            if (!any && req[idx]) begin
                any     = 1'b1;
                gnt_idx = PW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv && any) begin
            ptr <= (gnt_idx == PW'(W - 1)) ? '0 : gnt_idx + 1'b1;
        end
    end

endmodule

// File: rtl/hc_in_unit.sv
`timescale 1ns/1ps
module hc_in_unit import hc_pkg::*; #(
    parameter int N      = 4,
    parameter int HDR_W  = 36,
    parameter int FIFO_D = 2,
    parameter int SELF   = 0,
    localparam int PW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic          in_dat,
    input  logic          in_lst,
    output logic          in_rdy,
    output logic          req,
    output logic [PW-1:0] req_port,
    input  logic          gnt,
    output hc_beat_t      offer,
    input  logic          take
);
    localparam int AW = (FIFO_D > 1) ? $clog2(FIFO_D) : 1;
    localparam int CW = $clog2(FIFO_D + 1);
    localparam int HW = $clog2(HDR_W);
    localparam logic [N-1:0] SELF_V = N'(SELF);

    hc_bit_t     mem [FIFO_D];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    hc_bit_t     head;
    logic        hv, push, pop;

    hc_state_e   state;
    logic [HW-1:0] hcnt, tx_idx;
    logic [HDR_W-1:0] hdr, hdr_tx;
    logic [N-1:0] diff;
    int          low;

    assign in_rdy = (cnt < CW'(FIFO_D));
    assign push   = in_vld && in_rdy;
    assign hv     = (cnt != '0);
    assign head   = mem[rp];
    assign pop    = ((state == ST_HEAD) && hv) || ((state == ST_FWD) && take);

    // route: lowest differing dimension, local when equal
    assign diff = hdr[N-1:0] ^ SELF_V;
    assign low  = lowest_set(MAX_DIM'(diff));
    assign req_port = (low >= N) ? PW'(N) : PW'(low);

    always_comb begin
        hdr_tx = hdr;
        hdr_tx[N +: HOP_W] = hdr[N +: HOP_W] + HOP_W'(req_port != PW'(N));
    end

    assign req = (state == ST_ROUTE) && !gnt;

    always_comb begin
        offer = '0;
        if (state == ST_ROUTE && gnt) begin
            offer.vld = 1'b1;
            offer.dat = hdr_tx[tx_idx];
        end else if (state == ST_FWD) begin
            offer.vld = hv;
            offer.dat = head.dat;
            offer.lst = head.lst;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= '{dat: in_dat, lst: in_lst};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp     <= '0;
            rp     <= '0;
            cnt    <= '0;
            state  <= ST_HEAD;
            hcnt   <= '0;
            tx_idx <= '0;
            hdr    <= '0;
        end else begin
            if (push) wp <= (wp == AW'(FIFO_D - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(FIFO_D - 1)) ? '0 : rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            case (state)
                ST_HEAD: if (hv) begin
                    hdr <= {head.dat, hdr[HDR_W-1:1]};
                    if (hcnt == HW'(HDR_W - 1)) begin
                        hcnt   <= '0;
                        tx_idx <= '0;
                        state  <= ST_ROUTE;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_ROUTE: if (take) begin
                    if (tx_idx == HW'(HDR_W - 1)) state <= ST_FWD;
                    else tx_idx <= tx_idx + 1'b1;
                end
                ST_FWD: if (take && head.lst) state <= ST_HEAD;
                default: state <= ST_HEAD;
            endcase
        end
    end

    // R2: the last flag never arrives inside the header
    a_r2_no_last_in_header: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HEAD && hv) |-> !head.lst);

    // R5: forwarding dimension is the lowest one that differs
    a_r5_lowest_dim: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROUTE && req_port != PW'(N)) |->
        (diff[req_port] && ((diff & ((N'(1) << req_port) - N'(1))) == '0)));

    // R7: local delivery only when the addresses match
    a_r7_local_match: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROUTE && req_port == PW'(N)) |-> (hdr[N-1:0] == SELF_V));

endmodule

// File: rtl/hc_out_port.sv
`timescale 1ns/1ps
module hc_out_port import hc_pkg::*; #(
    parameter int P = 5,
    localparam int PW = $clog2(P)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [P-1:0]  req,
    input  hc_beat_t      offer [P],
    input  logic          down_rdy,
    output logic          busy,
    output logic [PW-1:0] owner,
    output logic          take,
    output logic          o_vld,
    output logic          o_dat,
    output logic          o_lst
);
    logic [PW-1:0] gidx;
    logic          any;
    logic [P-1:0]  req_m;
    hc_beat_t      sel;

    assign req_m = busy ? '0 : req;

    hc_rr_arb #(.W(P)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req_m),
        .adv     (!busy),
        .gnt_idx (gidx),
        .any     (any)
    );

    assign sel  = offer[owner];
    assign take = busy && sel.vld && (!o_vld || down_rdy);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            owner <= '0;
            o_vld <= 1'b0;
            o_dat <= 1'b0;
            o_lst <= 1'b0;
        end else begin
            if (!busy && any) begin
                busy  <= 1'b1;
                owner <= gidx;
            end else if (take && sel.lst) begin
                busy <= 1'b0;
            end
            if (take) begin
                o_vld <= 1'b1;
                o_dat <= sel.dat;
                o_lst <= sel.lst;
            end else if (down_rdy) begin
                o_vld <= 1'b0;
            end
        end
    end

    // R9: a stalled output holds its bit
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (o_vld && !down_rdy) |=> (o_vld && $stable(o_dat) && $stable(o_lst)));

    // R8: owner fixed until the last bit passes
    a_r8_owner_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && !(take && sel.lst)) |=> (busy && $stable(owner)));

    // R8: a free output with a requester is allocated next cycle
    a_r8_alloc: assert property (@(posedge clk) disable iff (rst)
        (!busy && (|req)) |=> busy);

endmodule

// File: rtl/hc_router.sv
`timescale 1ns/1ps
module hc_router import hc_pkg::*; #(
    parameter int N      = 4,
    parameter int HDR_W  = 36,
    parameter int FIFO_D = 2,
    parameter int SELF   = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lnk_in_vld,
    input  logic [N-1:0] lnk_in_dat,
    input  logic [N-1:0] lnk_in_lst,
    output logic [N-1:0] lnk_in_rdy,
    output logic [N-1:0] lnk_out_vld,
    output logic [N-1:0] lnk_out_dat,
    output logic [N-1:0] lnk_out_lst,
    input  logic [N-1:0] lnk_out_rdy,
    input  logic         inj_vld,
    input  logic         inj_dat,
    input  logic         inj_lst,
    output logic         inj_rdy,
    output logic         ej_vld,
    output logic         ej_dat,
    output logic         ej_lst
);
    localparam int P  = N + 1;
    localparam int PW = $clog2(P);

    logic          iv [P], idt [P], il [P], irdy [P];
    logic          in_req [P], in_gnt [P], in_take [P];
    logic [PW-1:0] in_port [P];
    hc_beat_t      offer [P];

    logic [P-1:0]  oreq [P];
    logic          busy [P], otake [P], down [P];
    logic [PW-1:0] owner [P];
    logic          ov [P], od [P], ol [P];

    for (genvar i = 0; i < P; i++) begin : g_in
        if (i < N) begin : g_lnk
            assign iv[i]  = lnk_in_vld[i];
            assign idt[i] = lnk_in_dat[i];
            assign il[i]  = lnk_in_lst[i];
            assign lnk_in_rdy[i] = irdy[i];
        end else begin : g_inj
            assign iv[i]  = inj_vld;
            assign idt[i] = inj_dat;
            assign il[i]  = inj_lst;
            assign inj_rdy = irdy[i];
        end

        assign in_gnt[i]  = busy[in_port[i]] && (owner[in_port[i]] == PW'(i));
        assign in_take[i] = in_gnt[i] && otake[in_port[i]];

        hc_in_unit #(.N(N), .HDR_W(HDR_W), .FIFO_D(FIFO_D), .SELF(SELF)) u_in (
            .clk      (clk),
            .rst      (rst),
            .in_vld   (iv[i]),
            .in_dat   (idt[i]),
            .in_lst   (il[i]),
            .in_rdy   (irdy[i]),
            .req      (in_req[i]),
            .req_port (in_port[i]),
            .gnt      (in_gnt[i]),
            .offer    (offer[i]),
            .take     (in_take[i])
        );
    end

    for (genvar p = 0; p < P; p++) begin : g_out
        for (genvar i = 0; i < P; i++) begin : g_req
            assign oreq[p][i] = in_req[i] && (in_port[i] == PW'(p));
        end

        if (p < N) begin : g_lnk
            assign down[p]        = lnk_out_rdy[p];
            assign lnk_out_vld[p] = ov[p];
            assign lnk_out_dat[p] = od[p];
            assign lnk_out_lst[p] = ol[p];
        end else begin : g_ej
            assign down[p] = 1'b1;
            assign ej_vld  = ov[p];
            assign ej_dat  = od[p];
            assign ej_lst  = ol[p];
        end

        hc_out_port #(.P(P)) u_out (
            .clk      (clk),
            .rst      (rst),
            .req      (oreq[p]),
            .offer    (offer),
            .down_rdy (down[p]),
            .busy     (busy[p]),
            .owner    (owner[p]),
            .take     (otake[p]),
            .o_vld    (ov[p]),
            .o_dat    (od[p]),
            .o_lst    (ol[p])
        );
    end

endmodule

// File: rtl/hc_net.sv
`timescale 1ns/1ps
module hc_net #(
    parameter int DIMS   = 4,
    parameter int HDR_W  = 36,
    parameter int FIFO_D = 2,
    localparam int NODES = 1 << DIMS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NODES-1:0] inj_vld,
    input  logic [NODES-1:0] inj_dat,
    input  logic [NODES-1:0] inj_lst,
    output logic [NODES-1:0] inj_rdy,
    output logic [NODES-1:0] ej_vld,
    output logic [NODES-1:0] ej_dat,
    output logic [NODES-1:0] ej_lst
);
    logic [DIMS-1:0] lo_vld [NODES], lo_dat [NODES], lo_lst [NODES], li_rdy [NODES];
    logic [DIMS-1:0] ri_vld [NODES], ri_dat [NODES], ri_lst [NODES], ro_rdy [NODES];

    for (genvar k = 0; k < NODES; k++) begin : g_node
        for (genvar d = 0; d < DIMS; d++) begin : g_dim
            assign ri_vld[k][d] = lo_vld[k ^ (1 << d)][d];
            assign ri_dat[k][d] = lo_dat[k ^ (1 << d)][d];
            assign ri_lst[k][d] = lo_lst[k ^ (1 << d)][d];
            assign ro_rdy[k][d] = li_rdy[k ^ (1 << d)][d];
        end

        hc_router #(.N(DIMS), .HDR_W(HDR_W), .FIFO_D(FIFO_D), .SELF(k)) u_rtr (
            .clk         (clk),
            .rst         (rst),
            .lnk_in_vld  (ri_vld[k]),
            .lnk_in_dat  (ri_dat[k]),
            .lnk_in_lst  (ri_lst[k]),
            .lnk_in_rdy  (li_rdy[k]),
            .lnk_out_vld (lo_vld[k]),
            .lnk_out_dat (lo_dat[k]),
            .lnk_out_lst (lo_lst[k]),
            .lnk_out_rdy (ro_rdy[k]),
            .inj_vld     (inj_vld[k]),
            .inj_dat     (inj_dat[k]),
            .inj_lst     (inj_lst[k]),
            .inj_rdy     (inj_rdy[k]),
            .ej_vld      (ej_vld[k]),
            .ej_dat      (ej_dat[k]),
            .ej_lst      (ej_lst[k])
        );
    end

endmodule

// File: tb/hc_net_tb.sv
`timescale 1ns/1ps
module hc_net_tb;
    localparam int DIMS  = 4;
    localparam int NODES = 1 << DIMS;
    localparam int HDR_W = 36;
    localparam int MAXM  = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NODES-1:0] inj_vld, inj_dat, inj_lst, inj_rdy, ej_vld, ej_dat, ej_lst;
    logic drv_v [NODES], drv_d [NODES], drv_l [NODES];

    always #2.5 clk = ~clk;

    hc_net #(.DIMS(DIMS), .HDR_W(HDR_W), .FIFO_D(2)) u_dut (
        .clk (clk), .rst (rst),
        .inj_vld (inj_vld), .inj_dat (inj_dat), .inj_lst (inj_lst), .inj_rdy (inj_rdy),
        .ej_vld (ej_vld), .ej_dat (ej_dat), .ej_lst (ej_lst)
    );

    int n_chk = 0, n_err = 0, n_msgs = 0, n_recv = 0, cyc = 0;
    int m_src [MAXM], m_dst [MAXM], m_len [MAXM], m_first [MAXM], m_done [MAXM];
    int last_id [NODES*NODES];
    bit saw_stall [NODES];
    bit done = 0;
    int q [NODES][$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic pbit(input int id, input int k);
        logic [7:0] t;
        if (k < 8) return id[k];
        t = 8'(id * 37 + k * 11);
        return ^(t & 8'h6D) ^ k[1];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver side of the scoreboard: record expectation, queue for injection
    task automatic post_msg(input int s, input int t, input int len);
        m_src[n_msgs] = s;
        m_dst[n_msgs] = t;
        m_len[n_msgs] = len;
        q[s].push_back(n_msgs);
        n_msgs++;
    endtask

    task automatic finish_msg(input int n, input logic [HDR_W-1:0] hdr, input int id,
                              input int len, input bit bad, input int first);
        int hop, exp_hop, key;
        n_recv++;
        if (id >= n_msgs) begin
            check(0, "R3 unknown message id", id, n_msgs);
            return;
        end
        check(n == m_dst[id], "R3 ejection node", n, m_dst[id]);
        check(int'(hdr[DIMS-1:0]) == m_dst[id] && hdr[HDR_W-1:DIMS+8] == '0,
              "R2 header fields", int'(hdr[DIMS-1:0]), m_dst[id]);
        check(len == m_len[id] && !bad, "R3/R8 payload intact", len, m_len[id]);
        hop = int'(hdr[DIMS +: 8]);
        exp_hop = $countones(m_src[id] ^ m_dst[id]);
        if (m_src[id] == m_dst[id]) check(hop == 0, "R7 self hop count", hop, 0);
        else check(hop == exp_hop, "R4 hop count", hop, exp_hop);
        key = m_src[id] * NODES + m_dst[id];
        check(id > last_id[key], "R5 same-pair order", id, last_id[key] + 1);
        last_id[key] = id;
        m_first[id] = first;
    endtask

    for (genvar n = 0; n < NODES; n++) begin : g_io
        assign inj_vld[n] = drv_v[n];
        assign inj_dat[n] = drv_d[n];
        assign inj_lst[n] = drv_l[n];

        initial begin : drv
            int id, total;
            logic b;
            drv_v[n] = 0; drv_d[n] = 0; drv_l[n] = 0;
            forever begin
                @(negedge clk);
                if (!rst && q[n].size() != 0) begin
                    id = q[n].pop_front();
                    total = HDR_W + m_len[id];
                    for (int k = 0; k < total; k++) begin
                        if (k > 0) @(negedge clk);
                        if (k < HDR_W) b = (k < DIMS) ? m_dst[id][k] : 1'b0;
                        else b = pbit(id, k - HDR_W);
                        drv_v[n] = 1; drv_d[n] = b; drv_l[n] = (k == total - 1);
                        while (!inj_rdy[n]) begin
                            saw_stall[n] = 1;
                            @(negedge clk);
                        end
                    end
                    m_done[id] = cyc;
                    @(negedge clk);
                    drv_v[n] = 0; drv_l[n] = 0;
                end
            end
        end

        // monitor side: rebuild each ejected message and score it
        int cnt = 0;
        int first = 0;
        bit bad = 0;
        logic [HDR_W-1:0] hdr;
        logic [7:0] idb;
        always @(negedge clk) begin
            if (rst) begin
                cnt = 0; bad = 0;
            end else if (ej_vld[n]) begin
                if (cnt == 0) first = cyc;
                if (cnt < HDR_W) hdr[cnt] = ej_dat[n];
                else if (cnt - HDR_W < 8) idb[cnt - HDR_W] = ej_dat[n];
                else if (ej_dat[n] !== pbit(int'(idb), cnt - HDR_W)) bad = 1;
                if (ej_lst[n]) begin
                    finish_msg(n, hdr, int'(idb), cnt - HDR_W + 1, bad, first);
                    cnt = 0; bad = 0;
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic wait_all();
        while (n_recv < n_msgs) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int id0;
        for (int i = 0; i < NODES*NODES; i++) last_id[i] = -1;
        for (int i = 0; i < NODES; i++) saw_stall[i] = 0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        // R1: reset state
        check(inj_rdy == '1, "R1 injection ready after reset", int'(inj_rdy), (1 << NODES) - 1);
        check(ej_vld == '0, "R1 ejection idle after reset", int'(ej_vld), 0);

        // R7: message to own node
        post_msg(5, 5, 16);
        wait_all();

        // R6: long message to a neighbour, cut-through
        id0 = n_msgs;
        post_msg(0, 1, 200);
        wait_all();
        check(m_first[id0] < m_done[id0], "R6 ejection starts before injection ends",
              m_first[id0], m_done[id0]);

        // R8 and R9: three neighbours of node 0 collide on its ejection port
        for (int i = 0; i < NODES; i++) saw_stall[i] = 0;
        post_msg(1, 0, 150);
        post_msg(2, 0, 150);
        post_msg(4, 0, 150);
        wait_all();
        check(saw_stall[1] || saw_stall[2] || saw_stall[4], "R9 blocked sender sees ready low",
              int'(saw_stall[1]) + int'(saw_stall[2]) + int'(saw_stall[4]), 1);

        // R5: repeated pair traffic in both directions
        post_msg(3, 12, 20);
        post_msg(3, 12, 24);
        post_msg(3, 12, 18);
        post_msg(12, 3, 30);
        post_msg(12, 3, 16);
        wait_all();

        // random pairs (R3, R4)
        for (int i = 0; i < 40; i++)
            post_msg(int'($urandom % NODES), int'($urandom % NODES), 16 + int'($urandom % 40));
        wait_all();

        check(n_recv == n_msgs, "R3 every message delivered", n_recv, n_msgs);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog R3: actual=%0d expected=%0d", n_recv, n_msgs);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule